// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers single-cycle event pulses from an audio-codec style peripheral into sticky status flags, masks them with a per-bit enable register, and requests service on an active-low, open-drain interrupt line. The line is only ever pulled low or released. The block presents it as a sink-enable output, and the pad's data input is tied low. A host reads the status register over a simple register bus. That read returns the pending flags, clears them and releases the request.

The enable register uses the same bit positions as the status register. Four positions are interrupt enables: clip detect (bit 7), slew level (bit 6), PLL unlock (bit 5) and jack detect (bit 1). Bit 2 of the enable register is not an enable. It selects the serial-data output delay and is exported unchanged on its own pin. The remaining positions read as zero.

The request is held by a two-state machine. `IRQ_RELEASED` moves to `IRQ_ASSERTED` on transition RAISE, when the next-cycle flags ANDed with the next-cycle enables are non-zero. `IRQ_ASSERTED` moves back to `IRQ_RELEASED` on transition SERVICE, which is a status read with no enabled event arriving in the same cycle. The machine stays in `IRQ_ASSERTED` on transition REARM, which is a status read while an enabled event arrives. With no status read, `IRQ_ASSERTED` holds.

Top module: `mis_irq_ctrl`

## Requirements
- R1: After reset, every flag and enable bit is zero, `irq_sink_o` is 0 (line released) and `sdo_dly_o` is 0.
- R2: A one-cycle pulse on `evt_i` bit 7, 6, 5 or 1 sets the flag at the same position, and the status register (address 0x00) reads it back.
- R3: A status read returns the flags held before the clock edge and clears them at that edge.
- R4: An event pulse in the same cycle as a status read is not lost: it is absent from that read and present in the next one.
- R5: `irq_sink_o` rises only when a flag and its enable are both set, and it rises at the edge that captures the event.
- R6: Writing an enable bit whose flag is already set makes `irq_sink_o` 1 at the edge of the write.
- R7: Once `irq_sink_o` is 1, it stays 1 until a status read, even if the enables are cleared.
- R8: After a status read, `irq_sink_o` is 0, unless an event arriving in that same cycle has its enable set. In that case it stays 1.
- R9: The enable register at address 0x04 stores bits 7, 6, 5, 2 and 1 on write and reads them back. Bits 4, 3 and 0 ignore writes and read as zero.
- R10: Bit 2 of the enable register drives `sdo_dly_o` and never causes an interrupt.
- R11: `evt_i` bits 4, 3, 2 and 0 have no effect on the flags or on `irq_sink_o`.
- R12: Writes to addresses other than 0x04 leave the enables unchanged, and reads of addresses other than 0x00 and 0x04 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, taken at the clock edge |
| bus_rd_i | input | 1 | Read strobe. A status read clears flags at the edge |
| bus_addr_i | input | AW | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational while the read strobe is high |
| evt_i | input | 8 | Event pulses, one cycle wide, at flag bit positions |
| irq_sink_o | output | 1 | 1 = pull the open-drain request line low, 0 = release it |
| sdo_dly_o | output | 1 | Serial-data output delay select |

## Verification
The bench sweeps all 256 enable values against every combination of the four event positions, with and without reserved event bits set. For each pair it checks the request, the status read-back and the enable read-back against values it computes arithmetically. The corner cases that get directed tests are these:
- An event that collides with a status read. A design that cleared unconditionally would drop that event.
- A read that collides with an enabled event. A design that released the line on every read would glitch it high for one cycle.
- Enabling a flag that is already set. A design that raised only on new events would never assert.
- Clearing the enables while the request is pending. A purely combinational mask would release the line without service.
- The delay bit. A design that treated bit 2 as an enable would raise spurious interrupts.

// File: rtl/mis_pkg.sv
package mis_pkg;
    localparam int unsigned REG_W = 8;

    // Bit positions shared by the status and enable registers
    localparam int unsigned BIT_CLIP   = 7;
    localparam int unsigned BIT_SLEW   = 6;
    localparam int unsigned BIT_UNLOCK = 5;
    localparam int unsigned BIT_DLY    = 2;
    localparam int unsigned BIT_JACK   = 1;

    localparam logic [REG_W-1:0] IRQ_BITS =
        REG_W'(1 << BIT_CLIP) | REG_W'(1 << BIT_SLEW) |
        REG_W'(1 << BIT_UNLOCK) | REG_W'(1 << BIT_JACK);
    localparam logic [REG_W-1:0] EN_WMASK = IRQ_BITS | REG_W'(1 << BIT_DLY);

    typedef enum logic {
        IRQ_RELEASED = 1'b0,
        IRQ_ASSERTED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/mis_flag_bank.sv
module mis_flag_bank
    import mis_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [REG_W-1:0] evt_i,
    input  logic             clr_i,
    output logic [REG_W-1:0] flag_q_o,
    output logic [REG_W-1:0] flag_d_o
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IRQ_BITS[i]) begin : g_live
            // a pulse in the clearing cycle wins over the clear
            assign flag_d_o[i] = evt_i[i] | (flag_q_o[i] & ~clr_i);
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) flag_q_o[i] <= 1'b0;
                else         flag_q_o[i] <= flag_d_o[i];
            end
        end else begin : g_tied
            assign flag_d_o[i] = 1'b0;
            assign flag_q_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/mis_regfile.sv
module mis_regfile
    import mis_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter logic [AW-1:0] ADDR_STAT = '0,
    parameter logic [AW-1:0] ADDR_EN   = AW'(4)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [REG_W-1:0] flag_q_i,
    output logic [REG_W-1:0] rdata_o,
    output logic [REG_W-1:0] en_q_o,
    output logic [REG_W-1:0] en_d_o,
    output logic             stat_rd_o
);
    logic en_wr;

    assign en_wr     = sel_i & wr_i & (addr_i == ADDR_EN);
    assign stat_rd_o = sel_i & rd_i & (addr_i == ADDR_STAT);
    assign en_d_o    = en_wr ? (wdata_i & EN_WMASK) : en_q_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q_o <= '0;
        else         en_q_o <= en_d_o;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i && rd_i) begin
            if (addr_i == ADDR_STAT)    rdata_o = flag_q_i;
            else if (addr_i == ADDR_EN) rdata_o = en_q_o;
        end
    end
endmodule

// File: rtl/mis_irq_fsm.sv
module mis_irq_fsm
    import mis_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pend_nxt_i,
    input  logic stat_rd_i,
    output logic sink_o
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_RELEASED: if (pend_nxt_i) state_d = IRQ_ASSERTED;           // RAISE
            IRQ_ASSERTED: if (stat_rd_i)
                              state_d = pend_nxt_i ? IRQ_ASSERTED           // REARM
                                                   : IRQ_RELEASED;          // SERVICE
            default:      state_d = IRQ_RELEASED;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= IRQ_RELEASED;
        else         state_q <= state_d;
    end

    always_comb begin
        sink_o = (state_q == IRQ_ASSERTED);
    end
endmodule

// File: rtl/mis_irq_ctrl.sv
module mis_irq_ctrl
    import mis_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter logic [AW-1:0] ADDR_STAT = '0,
    parameter logic [AW-1:0] ADDR_EN   = AW'(4)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bus_sel_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [AW-1:0]    bus_addr_i,
    input  logic [REG_W-1:0] bus_wdata_i,
    output logic [REG_W-1:0] bus_rdata_o,
    input  logic [REG_W-1:0] evt_i,
    output logic             irq_sink_o,
    output logic             sdo_dly_o
);
    logic [REG_W-1:0] flag_q, flag_d, en_q, en_d;
    logic             stat_rd, pend_nxt;

    mis_flag_bank u_flags (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .evt_i    (evt_i),
        .clr_i    (stat_rd),
        .flag_q_o (flag_q),
        .flag_d_o (flag_d)
    );

    mis_regfile #(.AW(AW), .ADDR_STAT(ADDR_STAT), .ADDR_EN(ADDR_EN)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sel_i     (bus_sel_i),
        .wr_i      (bus_wr_i),
        .rd_i      (bus_rd_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .flag_q_i  (flag_q),
        .rdata_o   (bus_rdata_o),
        .en_q_o    (en_q),
        .en_d_o    (en_d),
        .stat_rd_o (stat_rd)
    );

    assign pend_nxt = |(flag_d & en_d & IRQ_BITS);

    mis_irq_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pend_nxt_i (pend_nxt),
        .stat_rd_i  (stat_rd),
        .sink_o     (irq_sink_o)
    );

    assign sdo_dly_o = en_q[BIT_DLY];
endmodule

// File: rtl/mis_irq_ctrl_chk.sv
module mis_irq_ctrl_chk
    import mis_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter logic [AW-1:0] ADDR_EN = AW'(4)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             bus_sel_i,
    input logic             bus_rd_i,
    input logic [AW-1:0]    bus_addr_i,
    input logic [REG_W-1:0] bus_rdata_o,
    input logic [REG_W-1:0] evt_i,
    input logic             stat_rd,
    input logic [REG_W-1:0] flag_q,
    input logic [REG_W-1:0] en_q,
    input logic             irq_sink_o
);
    // R5
    irq_needs_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_sink_o) |-> ((flag_q & en_q) != '0));

    // R3
    read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_rd |=> ((flag_q & ~$past(evt_i)) == '0));

    // R7
    irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_sink_o && !stat_rd) |=> irq_sink_o);

    // R9
    reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && bus_rd_i && bus_addr_i == ADDR_EN) |-> ((bus_rdata_o & ~EN_WMASK) == '0));

    // R11
    flag_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q & ~IRQ_BITS) == '0);
endmodule

bind mis_irq_ctrl mis_irq_ctrl_chk #(.AW(AW), .ADDR_EN(ADDR_EN)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .evt_i       (evt_i),
    .stat_rd     (stat_rd),
    .flag_q      (flag_q),
    .en_q        (en_q),
    .irq_sink_o  (irq_sink_o)
);

// File: tb/mis_irq_ctrl_bench.sv
`timescale 1ns/1ps
module mis_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] addr = '0, wdata = '0, evt = '0;
    logic [7:0] rdata;
    logic       sink, dly;
    int         total = 0, bad = 0;
    bit         done = 1'b0;
    logic [7:0] d;

    localparam logic [7:0] IRQM = 8'hE2;
    localparam logic [7:0] ENM  = 8'hE6;

    always #2.5 clk = ~clk;

    mis_irq_ctrl u_mis_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .evt_i(evt), .irq_sink_o(sink), .sdo_dly_o(dly)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
        sel = 1; wr = 1; addr = a; wdata = v;
        @(negedge clk);
        sel = 0; wr = 0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [7:0] ev, output logic [7:0] v);
        sel = 1; rd = 1; addr = a; evt = ev;
        #1 v = rdata;
        @(negedge clk);
        sel = 0; rd = 0; evt = 0;
    endtask

    task automatic pulse(input logic [7:0] v);
        evt = v;
        @(negedge clk);
        evt = 0;
    endtask

    function automatic logic [7:0] spread(input int v);
        logic [7:0] p;
        p = {v[3], v[2], v[1], 3'b000, v[0], 1'b0};
        if (v[4]) p = p | 8'h1D;   // reserved positions and the delay position
        return p;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(sink == 0, "R1 sink", sink, 0);
        chk(dly == 0, "R1 dly", dly, 0);
        rd_reg(8'h00, 8'h00, d); chk(d == 0, "R1 status", d, 0);
        rd_reg(8'h04, 8'h00, d); chk(d == 0, "R1 enable", d, 0);

        // R4/R8: collision with enabled event keeps the request
        wr_reg(8'h04, 8'hE2);
        pulse(8'h80);
        chk(sink == 1, "R5 raise", sink, 1);
        rd_reg(8'h00, 8'h20, d);
        chk(d == 8'h80, "R4 read old", d, 8'h80);
        chk(sink == 1, "R8 rearm", sink, 1);
        rd_reg(8'h00, 8'h00, d);
        chk(d == 8'h20, "R4 kept", d, 8'h20);
        chk(sink == 0, "R8 service", sink, 0);

        // R8: collision with disabled event releases, flag kept
        wr_reg(8'h04, 8'h80);
        pulse(8'h80);
        rd_reg(8'h00, 8'h02, d);
        chk(sink == 0, "R8 released", sink, 0);
        rd_reg(8'h00, 8'h00, d);
        chk(d == 8'h02, "R4 kept masked", d, 8'h02);

        // R6/R7: late enable, then enable cleared while pending
        wr_reg(8'h04, 8'h00);
        pulse(8'h40);
        chk(sink == 0, "R5 masked", sink, 0);
        wr_reg(8'h04, 8'h40);
        chk(sink == 1, "R6 late enable", sink, 1);
        wr_reg(8'h04, 8'h00);
        repeat (3) @(negedge clk);
        chk(sink == 1, "R7 hold", sink, 1);
        rd_reg(8'h00, 8'h00, d);
        chk(d == 8'h40, "R3 read", d, 8'h40);
        chk(sink == 0, "R7 service", sink, 0);

        // R12 other addresses
        wr_reg(8'h04, 8'hE6);
        wr_reg(8'h08, 8'h00);
        wr_reg(8'h00, 8'h00);
        rd_reg(8'h04, 8'h00, d); chk(d == 8'hE6, "R12 write ignored", d, 8'hE6);
        rd_reg(8'h10, 8'h00, d); chk(d == 8'h00, "R12 read zero", d, 0);

        // R10 delay bit
        wr_reg(8'h04, 8'h04);
        chk(dly == 1, "R10 dly", dly, 1);
        pulse(8'h1D);
        chk(sink == 0, "R10 no irq", sink, 0);
        rd_reg(8'h00, 8'h00, d); chk(d == 0, "R11 no flag", d, 0);

        // sweep: every enable value against every event pattern
        for (int e = 0; e < 256; e++) begin
            for (int v = 0; v < 32; v++) begin
                logic [7:0] ev;
                logic       exp_irq;
                ev = spread(v);
                exp_irq = |(ev & e[7:0] & IRQM);
                wr_reg(8'h04, e[7:0]);
                rd_reg(8'h04, 8'h00, d);
                chk(d == (e[7:0] & ENM), "R9 enable readback", d, e[7:0] & ENM);
                chk(dly == e[2], "R10 dly sweep", dly, e[2]);
                pulse(ev);
                chk(sink == exp_irq, "R5 R11 sweep irq", sink, exp_irq);
                rd_reg(8'h00, 8'h00, d);
                chk(d == (ev & IRQM), "R2 status sweep", d, ev & IRQM);
                chk(sink == 0, "R8 sweep release", sink, 0);
                rd_reg(8'h00, 8'h00, d);
                chk(d == 0, "R3 sweep cleared", d, 0);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule